// File: doc/BRIEF.md
# Dual-Output Match-Based PWM Timer

This block is one timer channel that produces two pulse-width-modulated outputs from a single 16-bit up-counter. A shared power-of-four prescaler sets the rate at which the counter advances. Each output owns two 16-bit match values, a period value and a duty value. A control bit picks which of the two period values wraps the shared counter. Each output compares the counter against its own pair of match values to form its waveform.

Software programs the channel through a simple write port and a combinational read port. Match values are written into shadow copies. While the counter runs, the copies move into the working set only when the counter wraps, so a period in progress is never cut short or stretched. An output that is turned off, or whose channel is stopped, drops its output enable so the pad floats.

Top module: `dual_pwm_timer`

## Requirements
- R1: After a synchronous reset the counter reads 0, the control word reads 0, the mode word reads 0 and both output enables are low.
- R2: While running with prescale code k (control bits 2:1), the counter advances once every 4^k input clock cycles (codes 0..3 give 1, 4, 16, 64). While stopped (control bit 0 low) the counter holds its value.
- R3: A write to the control word while the channel is running leaves the prescale code unchanged (readback keeps the old code), while the run and clear-select bits are still taken.
- R4: The counter counts 0,1,...,P and then returns to 0 on the next advance, where P is the working period of output 0 (match A, address 2) when control bit 3 is 0, or of output 1 (match C, address 4) when it is 1.
- R5: For an enabled output with period P and duty D, 0 < D < P, the output is high exactly when the counter is below D or at least P. Output 0 uses A/B (addresses 2/3), output 1 uses C/D (addresses 4/5).
- R6: An enabled output with D >= P and D != 0 is high at every count; an enabled output with D = 0 is low at every count.
- R7: While running, a match-value write takes effect at the next counter wrap; the period in progress finishes with the old value. While stopped, a written value is in force two cycles after the write.
- R8: Output n's enable (pwm_oe[n]) is high only while the channel runs and mode bit n (address 1) is set; whenever the enable is low, pwm_o[n] is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 mode, 2..5 match A..D |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address: as write, plus 6 for the counter |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| pwm_o | output | 2 | Output levels, bit n for output n |
| pwm_oe | output | 2 | Output drive enables; low means the pin floats |

## Verification
The waveform is tried with an ordinary duty on output 0, a duty on output 1 whose period differs from the wrapping period, a duty above the period and a zero duty. The ordinary cases separate the below-duty and at-period parts of the high time, and the extreme cases separate the override rules from plain comparison. Counter spacing is measured under three prescale codes and under an attempted code change while running, which tells a locked prescaler from one that follows every write. Wrap points are measured with each clear source and across a period rewrite in mid-cycle, which distinguishes shadowed from immediate loading.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  typedef enum logic [2:0] {
    ADR_CTRL = 3'd0,
    ADR_MODE = 3'd1,
    ADR_PA   = 3'd2,
    ADR_DA   = 3'd3,
    ADR_PC   = 3'd4,
    ADR_DC   = 3'd5,
    ADR_CNT  = 3'd6
  } reg_addr_e;

  localparam int LIM_W = 6;

  // Number of input cycles per counter advance, minus one: 4^code - 1.
  function automatic logic [LIM_W-1:0] presc_limit(input logic [1:0] code);
    logic [LIM_W:0] one_hot;
    one_hot = (LIM_W+1)'(1) << (2 * code);
    return LIM_W'(one_hot - (LIM_W+1)'(1));
  endfunction

  // Output level for a count against a period/duty pair.
  function automatic logic pwm_level(input logic [31:0] cnt,
                                     input logic [31:0] per,
                                     input logic [31:0] duty);
    if (duty == 32'd0) return 1'b0;
    if (duty >= per) return 1'b1;
    return (cnt < duty) || (cnt >= per);
  endfunction

endpackage

// File: rtl/dpwm_presc.sv
module dpwm_presc
  import dpwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] code,
  output logic       tick
);
  logic [LIM_W-1:0] pcnt_q;
  logic [LIM_W-1:0] limit;

  assign limit = presc_limit(code);
  assign tick  = run && (pcnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) pcnt_q <= '0;
    else                     pcnt_q <= pcnt_q + LIM_W'(1);
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick && limit != '0) |=> !tick); // R2

endmodule

// File: rtl/dpwm_count.sv
module dpwm_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [CW-1:0] per,
  output logic [CW-1:0] cnt,
  output logic          clr_evt
);
  logic [CW-1:0] cnt_q;

  assign clr_evt = tick && (cnt_q >= per);
  assign cnt     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (clr_evt) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + CW'(1);
  end

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q >= per) |=> (cnt_q == '0)); // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dpwm_pkg::*;
#(
  parameter int CW    = 16,
  parameter int N_OUT = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [2:0]                 wr_addr,
  input  logic [CW-1:0]              wr_data,
  input  logic [2:0]                 rd_addr,
  input  logic [CW-1:0]              cnt_i,
  input  logic                       load_evt,
  output logic [CW-1:0]              rd_data,
  output logic                       run,
  output logic [1:0]                 presc,
  output logic                       clr_sel,
  output logic [N_OUT-1:0]           mode,
  output logic [2*N_OUT-1:0][CW-1:0] act
);
  localparam int NM = 2 * N_OUT;

  logic                    run_q;
  logic [1:0]              presc_q;
  logic                    clr_sel_q;
  logic [N_OUT-1:0]        mode_q;
  logic [NM-1:0][CW-1:0]   shadow_q;
  logic [NM-1:0][CW-1:0]   act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      presc_q   <= '0;
      clr_sel_q <= 1'b0;
      mode_q    <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADR_CTRL) begin
        run_q     <= wr_data[0];
        clr_sel_q <= wr_data[3];
        if (!run_q) presc_q <= wr_data[2:1];
      end
      if (wr_addr == ADR_MODE) mode_q <= wr_data[N_OUT-1:0];
    end
  end

  for (genvar i = 0; i < NM; i++) begin : g_match
    localparam logic [2:0] MY_ADDR = 3'(int'(ADR_PA) + i);
    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q[i] <= '0;
        act_q[i]    <= '0;
      end else begin
        if (wr_en && wr_addr == MY_ADDR) shadow_q[i] <= wr_data;
        if (!run_q || load_evt)          act_q[i]    <= shadow_q[i];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_CTRL: rd_data = CW'({clr_sel_q, presc_q, run_q});
      ADR_MODE: rd_data = CW'(mode_q);
      ADR_PA:   rd_data = shadow_q[0];
      ADR_DA:   rd_data = shadow_q[1];
      ADR_PC:   rd_data = shadow_q[2];
      ADR_DC:   rd_data = shadow_q[3];
      ADR_CNT:  rd_data = cnt_i;
      default:  rd_data = '0;
    endcase
  end

  assign run     = run_q;
  assign presc   = presc_q;
  assign clr_sel = clr_sel_q;
  assign mode    = mode_q;
  assign act     = act_q;

  AST_PRESC_LOCK: assert property (@(posedge clk) disable iff (rst)
    run_q |=> $stable(presc_q)); // R3
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run_q && !load_evt) |=> $stable(act_q)); // R7

endmodule

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer
  import dpwm_pkg::*;
#(
  parameter int CW    = 16,
  parameter int N_OUT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CW-1:0]    wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CW-1:0]    rd_data,
  output logic [N_OUT-1:0] pwm_o,
  output logic [N_OUT-1:0] pwm_oe
);
  logic                       run;
  logic [1:0]                 presc;
  logic                       clr_sel;
  logic [N_OUT-1:0]           mode;
  logic [2*N_OUT-1:0][CW-1:0] act;
  logic                       tick;
  logic                       clr_evt;
  logic [CW-1:0]              cnt;
  logic [CW-1:0]              clr_per;

  dpwm_regs #(.CW(CW), .N_OUT(N_OUT)) u_regs (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr,
    .cnt_i(cnt), .load_evt(clr_evt), .rd_data,
    .run, .presc, .clr_sel, .mode, .act
  );

  dpwm_presc u_presc (
    .clk, .rst, .run, .code(presc), .tick
  );

  // Clear source: period of output 0 (A) or of output 1 (C).
  assign clr_per = clr_sel ? act[2] : act[0];

  dpwm_count #(.CW(CW)) u_count (
    .clk, .rst, .tick, .per(clr_per), .cnt, .clr_evt
  );

  for (genvar n = 0; n < N_OUT; n++) begin : g_out
    logic lvl;
    assign lvl       = pwm_level(32'(cnt), 32'(act[2*n]), 32'(act[2*n+1]));
    assign pwm_oe[n] = run && mode[n];
    assign pwm_o[n]  = pwm_oe[n] && lvl;
  end

endmodule

// File: tb/test_dual_pwm_timer.sv
module test_dual_pwm_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  pwm_o, pwm_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int m_per[2];
  int m_duty[2];
  bit [1:0] m_mode;
  bit m_run;

  dual_pwm_timer i_dual_pwm_timer (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data, .pwm_o, .pwm_oe
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  // ctrl word: bit0 run, bits 2:1 prescale code, bit3 clear select
  task automatic ctrl(input bit run, input int code, input bit sel);
    wr(3'd0, (int'(sel) << 3) | (code << 1) | int'(run));
    m_run = run;
  endtask

  function automatic bit exp_lvl(int c, int p, int d);
    if (d == 0) return 1'b0;
    if (d >= p) return 1'b1;
    return !(c >= d && c < p);
  endfunction

  task automatic check_wave(input string req, input int ncyc);
    int c;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      rd(3'd6, c);
      for (int n = 0; n < 2; n++) begin
        bit eo = m_run && m_mode[n];
        chk(req, $sformatf("oe%0d at cnt %0d", n, c), int'(pwm_oe[n]), int'(eo));
        chk(req, $sformatf("out%0d at cnt %0d", n, c), int'(pwm_o[n]),
            int'(eo && exp_lvl(c, m_per[n], m_duty[n])));
      end
    end
  endtask

  // value held just before the next return of the counter to 0
  task automatic next_wrap(output int pt);
    int c, prev;
    prev = -1; pt = -1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      rd(3'd6, c);
      if (c == 0 && prev > 0) begin pt = prev; break; end
      prev = c;
    end
  endtask

  // input cycles between two successive counter changes
  task automatic spacing(output int gap);
    int c0, c;
    gap = 0;
    rd(3'd6, c0);
    for (int k = 0; k < 300; k++) begin
      @(negedge clk); rd(3'd6, c);
      if (c != c0) break;
    end
    c0 = c;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk); rd(3'd6, c); gap++;
      if (c != c0) break;
    end
  endtask

  task automatic set_match(input int a, input int b, input int cc, input int d);
    wr(3'd2, a); wr(3'd3, b); wr(3'd4, cc); wr(3'd5, d);
    m_per[0] = a; m_duty[0] = b; m_per[1] = cc; m_duty[1] = d;
  endtask

  task automatic t_reset();
    int v;
    rd(3'd6, v); chk("R1", "counter", v, 0);
    rd(3'd0, v); chk("R1", "control", v, 0);
    rd(3'd1, v); chk("R1", "mode", v, 0);
    chk("R1", "oe", int'(pwm_oe), 0);
  endtask

  task automatic t_basic();
    int pt;
    set_match(9, 3, 5, 2);
    wr(3'd1, 3); m_mode = 2'b11;
    repeat (2) @(negedge clk);
    ctrl(1, 0, 0);
    check_wave("R5", 40);
    next_wrap(pt); next_wrap(pt);
    chk("R4", "wrap point, clear from A", pt, 9);
  endtask

  task automatic t_prescale();
    int g;
    int codes[3] = '{1, 2, 3};
    int gaps[3]  = '{4, 16, 64};
    for (int i = 0; i < 3; i++) begin
      ctrl(0, 0, 0);
      ctrl(0, codes[i], 0);
      ctrl(1, codes[i], 0);
      spacing(g);
      chk("R2", $sformatf("gap for code %0d", codes[i]), g, gaps[i]);
    end
  endtask

  task automatic t_lock();
    int v, g;
    ctrl(0, 0, 0);
    ctrl(0, 1, 0);
    ctrl(1, 1, 0);
    ctrl(1, 3, 0);
    rd(3'd0, v);
    chk("R3", "control readback keeps code 1", v, 3);
    spacing(g);
    chk("R3", "gap after locked write", g, 4);
  endtask

  task automatic t_clrsel();
    int pt;
    ctrl(0, 0, 0);
    set_match(9, 3, 6, 2);
    repeat (2) @(negedge clk);
    ctrl(1, 0, 1);
    next_wrap(pt); next_wrap(pt);
    chk("R4", "wrap point, clear from C", pt, 6);
    ctrl(0, 0, 0);
  endtask

  task automatic t_edge();
    int hi0, hi1;
    ctrl(0, 0, 0);
    set_match(9, 20, 5, 0);
    repeat (2) @(negedge clk);
    ctrl(1, 0, 0);
    check_wave("R6", 25);
    hi0 = 0; hi1 = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); #1;
      hi0 += int'(pwm_o[0]); hi1 += int'(pwm_o[1]);
    end
    chk("R6", "out0 high cycles, duty above period", hi0, 20);
    chk("R6", "out1 high cycles, zero duty", hi1, 0);
  endtask

  task automatic t_shadow();
    int c, pt, v;
    ctrl(0, 0, 0);
    set_match(9, 3, 5, 2);
    repeat (2) @(negedge clk);
    ctrl(1, 0, 0);
    next_wrap(pt);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); rd(3'd6, c);
      if (c == 5) break;
    end
    wr(3'd2, 4);
    next_wrap(pt);
    chk("R7", "wrap in progress keeps old period", pt, 9);
    next_wrap(pt);
    chk("R7", "wrap after reload uses new period", pt, 4);
    ctrl(0, 0, 0);
    wr(3'd2, 7);
    wr(3'd0, 1);
    m_run = 1; m_per[0] = 7;
    next_wrap(pt); next_wrap(pt);
    chk("R7", "stopped write in force at start", pt, 7);
    rd(3'd2, v);
    chk("R7", "shadow readback", v, 7);
  endtask

  task automatic t_oe();
    int c0, c1;
    wr(3'd1, 1); m_mode = 2'b01;
    @(negedge clk); #1;
    chk("R8", "oe with one mode bit", int'(pwm_oe), 1);
    chk("R8", "out1 low while disabled", int'(pwm_o[1]), 0);
    check_wave("R8", 10);
    ctrl(0, 0, 0);
    #1;
    chk("R8", "oe when stopped", int'(pwm_oe), 0);
    chk("R8", "out when stopped", int'(pwm_o), 0);
    rd(3'd6, c0);
    repeat (5) @(negedge clk);
    rd(3'd6, c1);
    chk("R2", "counter holds while stopped", c1, c0);
  endtask

  initial begin
    m_mode = '0; m_run = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_prescale();
    t_lock();
    t_clrsel();
    t_edge();
    t_shadow();
    t_oe();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule